// File: doc/BRIEF.md
# Dual-Lane Ternary Release Interlock

This block releases an action only when two independent verdict sources agree. A processing lane and a governance lane each present a three-valued verdict on a 2-bit dual-rail code. The gate keeps a registered ternary output that moves to a new data value only when both lanes show that same value. It holds its value whenever the lanes disagree or either lane is empty, in the manner of a C-element.

A governance injection input forces the output to the empty (pause) value and locks the gate. The lock is lifted only by a two-step handshake: a ready signal first, then an acknowledge in a later cycle. A proceed verdict is released only in a cycle where the log acknowledge confirms that a record was stored. Every change of the output emits a one-cycle record strobe. The strobe carries the new state, a caller-supplied context tag and a cycle timestamp. A pause that outlasts a programmable cycle limit raises an escalation flag.

Top module: `tern_release_gate`

## Requirements
- R1: Verdicts use the dual-rail code 2'b10 for proceed, 2'b01 for refuse and 2'b00 for pause (NULL). After reset `verdict_o` is 2'b00, `rec_valid_o`, `escalate_o` and `lane_err_o` are 0, and the gate is locked.
- R2: While unlocked, if both lanes carry the same non-NULL value in a cycle, `verdict_o` takes that value at the next clock edge (subject to R3). If the lanes differ or either lane is NULL, `verdict_o` keeps its value.
- R3: A change of `verdict_o` to proceed happens only at an edge where `log_ack_i` is 1 together with agreeing proceed lanes. Without `log_ack_i` the output holds.
- R4: `inject_i` high at an edge makes `verdict_o` 2'b00 after that edge, whatever the lanes carry, and locks the gate.
- R5: A locked gate ignores the lanes. `gov_ready_i` at an edge arms the release. A `resume_ack_i` at a later edge unlocks the gate. Lane values are then taken from the edge after that. An acknowledge that comes before a ready is ignored.
- R6: At every edge where `verdict_o` changes, `rec_valid_o` is 1 for one cycle. With it, `rec_state_o` shows the new verdict and `rec_ctx_o` shows `ctx_i` as sampled at that edge. At all other edges `rec_valid_o` is 0.
- R7: `rec_time_o` is a 32-bit free-running edge counter, cleared by reset. Its value is the number of edges since reset that came before the recording edge.
- R8: `escalate_o` is 1 while `verdict_o` is NULL and has been NULL for at least `pause_limit_i` completed cycles. It drops as soon as `verdict_o` is a data value.
- R9: Lane code 2'b11 is treated as NULL. It sets `lane_err_o`, which stays set until reset.
- R10: `inject_i` takes priority over `gov_ready_i` and `resume_ack_i` in the same cycle. The gate stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane1_i | input | 2 | Processing-lane verdict, dual-rail |
| lane2_i | input | 2 | Governance-lane verdict, dual-rail |
| inject_i | input | 1 | Governance pause injection |
| gov_ready_i | input | 1 | Release step one: governance ready |
| resume_ack_i | input | 1 | Release step two: acknowledge |
| log_ack_i | input | 1 | Record stored; permits a proceed release |
| ctx_i | input | CTX_W | Context tag copied into records |
| pause_limit_i | input | LIM_W | Pause length in cycles before escalation |
| verdict_o | output | 2 | Released ternary verdict, dual-rail |
| rec_valid_o | output | 1 | Record strobe, one cycle per verdict change |
| rec_state_o | output | 2 | Verdict carried by the record |
| rec_ctx_o | output | CTX_W | Context tag carried by the record |
| rec_time_o | output | TS_W | Timestamp carried by the record |
| escalate_o | output | 1 | Pause exceeded its limit |
| lane_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The internal lock state has no port of its own. A wrong lock state shows in `verdict_o` one edge after the lanes agree: the output either moves too early during a handshake or stays frozen after a release. A wrong pause counter shows in `escalate_o` in the cycle the limit is crossed. A wrong timestamp shows in the next record strobe. The reference model tracks each of these from port stimulus alone and compares every output on every cycle, so any divergence is caught within one cycle of reaching a port.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef enum logic [1:0] {
    TV_NULL    = 2'b00,
    TV_REFUSE  = 2'b01,
    TV_PROCEED = 2'b10,
    TV_BAD     = 2'b11
  } tern_t;

  typedef enum logic [1:0] {
    GS_LOCKED = 2'b00,
    GS_ARMED  = 2'b01,
    GS_RUN    = 2'b10
  } gate_st_t;
endpackage

// File: rtl/tern_lane_check.sv
module tern_lane_check
  import tern_pkg::*;
(
  input  logic [1:0] lane_i,
  output tern_t      clean_o,
  output logic       bad_o
);
  assign bad_o   = (lane_i == 2'b11);
  // illegal code collapses to NULL
  assign clean_o = bad_o ? TV_NULL : tern_t'(lane_i);
endmodule

// File: rtl/tern_resume_ctl.sv
module tern_resume_ctl
  import tern_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inject_i,
  input  logic ready_i,
  input  logic ack_i,
  output logic run_o
);
  gate_st_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (inject_i) state_d = GS_LOCKED;
    else begin
      unique case (state_q)
        GS_LOCKED: if (ready_i) state_d = GS_ARMED;
        GS_ARMED:  if (ack_i)   state_d = GS_RUN;
        GS_RUN:    state_d = GS_RUN;
        default:   state_d = GS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GS_LOCKED;
    else         state_q <= state_d;
  end

  assign run_o = (state_q == GS_RUN);

  assert_run_via_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !$past(run_o)) |-> ($past(state_q) == GS_ARMED && $past(ack_i) && !$past(inject_i)));

  assert_inject_locks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_i |=> (state_q == GS_LOCKED));
endmodule

// File: rtl/tern_pause_timer.sv
module tern_pause_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             paused_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             escalate_o
);
  localparam logic [LIM_W-1:0] CntMax = {LIM_W{1'b1}};

  logic [LIM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!paused_i)         cnt_q <= '0;
    else if (cnt_q != CntMax)   cnt_q <= cnt_q + 1'b1;
  end

  assign escalate_o = paused_i && (cnt_q >= limit_i);

  assert_fresh_pause_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(paused_i) && limit_i != '0) |-> !escalate_o);
endmodule

// File: rtl/tern_release_gate.sv
module tern_release_gate
  import tern_pkg::*;
#(
  parameter int CTX_W = 8,
  parameter int LIM_W = 16,
  parameter int TS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       lane1_i,
  input  logic [1:0]       lane2_i,
  input  logic             inject_i,
  input  logic             gov_ready_i,
  input  logic             resume_ack_i,
  input  logic             log_ack_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [LIM_W-1:0] pause_limit_i,
  output logic [1:0]       verdict_o,
  output logic             rec_valid_o,
  output logic [1:0]       rec_state_o,
  output logic [CTX_W-1:0] rec_ctx_o,
  output logic [TS_W-1:0]  rec_time_o,
  output logic             escalate_o,
  output logic             lane_err_o
);
  localparam int NLANE = 2;

  logic [1:0]       lane_raw [NLANE];
  tern_t            lane_c   [NLANE];
  logic [NLANE-1:0] lane_bad;

  assign lane_raw[0] = lane1_i;
  assign lane_raw[1] = lane2_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    tern_lane_check u_chk (
      .lane_i  (lane_raw[g]),
      .clean_o (lane_c[g]),
      .bad_o   (lane_bad[g])
    );
  end

  logic run;
  tern_resume_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inject_i (inject_i),
    .ready_i  (gov_ready_i),
    .ack_i    (resume_ack_i),
    .run_o    (run)
  );

  tern_t            verdict_q, verdict_d, rec_state_q;
  logic             rec_valid_q, err_q;
  logic [CTX_W-1:0] rec_ctx_q;
  logic [TS_W-1:0]  ts_q, rec_time_q;
  logic             agree, change;

  assign agree = (lane_c[0] == lane_c[1]) && (lane_c[0] != TV_NULL);

  always_comb begin
    verdict_d = verdict_q;
    if (inject_i) verdict_d = TV_NULL;
    else if (run && agree && lane_c[0] != verdict_q) begin
      // no proceed without a stored record
      if (lane_c[0] != TV_PROCEED || log_ack_i) verdict_d = lane_c[0];
    end
  end

  assign change = (verdict_d != verdict_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_q   <= TV_NULL;
      rec_valid_q <= 1'b0;
      rec_state_q <= TV_NULL;
      rec_ctx_q   <= '0;
      rec_time_q  <= '0;
      ts_q        <= '0;
      err_q       <= 1'b0;
    end else begin
      verdict_q   <= verdict_d;
      rec_valid_q <= change;
      ts_q        <= ts_q + 1'b1;
      if (|lane_bad) err_q <= 1'b1;
      if (change) begin
        rec_state_q <= verdict_d;
        rec_ctx_q   <= ctx_i;
        rec_time_q  <= ts_q;
      end
    end
  end

  tern_pause_timer #(.LIM_W(LIM_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .paused_i   (verdict_q == TV_NULL),
    .limit_i    (pause_limit_i),
    .escalate_o (escalate_o)
  );

  assign verdict_o   = verdict_q;
  assign rec_valid_o = rec_valid_q;
  assign rec_state_o = rec_state_q;
  assign rec_ctx_o   = rec_ctx_q;
  assign rec_time_o  = rec_time_q;
  assign lane_err_o  = err_q;

  assert_inject_null_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_i |=> (verdict_o == 2'b00));

  assert_proceed_logged_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == 2'b10 && $past(verdict_o) != 2'b10) |-> $past(log_ack_i));

  assert_record_on_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o != $past(verdict_o)) |-> (rec_valid_o && rec_state_o == verdict_o));

  assert_data_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o != $past(verdict_o) && verdict_o != 2'b00) |-> $past(run));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lane_err_o) |-> lane_err_o);

  assert_legal_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'b11);
endmodule

// File: tb/tern_release_gate_test.sv
module tern_release_gate_test;
  localparam int CTX_W = 8;
  localparam int LIM_W = 16;
  localparam int TS_W  = 32;
  localparam int LIMIT = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] lane1, lane2;
  logic inject, ready, ack, log_ack;
  logic [CTX_W-1:0] ctx;
  logic [LIM_W-1:0] limit;
  logic [1:0] verdict, rec_state;
  logic rec_valid, escalate, lane_err;
  logic [CTX_W-1:0] rec_ctx;
  logic [TS_W-1:0] rec_time;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  tern_release_gate #(.CTX_W(CTX_W), .LIM_W(LIM_W), .TS_W(TS_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .lane1_i(lane1), .lane2_i(lane2),
    .inject_i(inject), .gov_ready_i(ready), .resume_ack_i(ack),
    .log_ack_i(log_ack), .ctx_i(ctx), .pause_limit_i(limit),
    .verdict_o(verdict), .rec_valid_o(rec_valid), .rec_state_o(rec_state),
    .rec_ctx_o(rec_ctx), .rec_time_o(rec_time), .escalate_o(escalate),
    .lane_err_o(lane_err)
  );

  // behavioural reference model
  int m_ts, m_st, m_pc;
  logic [1:0] m_v, m_rs;
  logic m_rv, m_err;
  logic [CTX_W-1:0] m_rc;
  int m_rt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ts = 0; m_st = 0; m_pc = 0; m_v = 2'b00; m_rs = 2'b00;
      m_rv = 1'b0; m_err = 1'b0; m_rc = '0; m_rt = 0;
    end else begin
      logic [1:0] a, b, nv;
      int ns;
      a = (lane1 == 2'b11) ? 2'b00 : lane1;
      b = (lane2 == 2'b11) ? 2'b00 : lane2;
      nv = m_v; ns = m_st;
      if (inject) begin ns = 0; nv = 2'b00; end
      else if (m_st == 0) begin if (ready) ns = 1; end
      else if (m_st == 1) begin if (ack) ns = 2; end
      else if (a == b && a != 2'b00 && a != m_v) begin
        if (a == 2'b01 || log_ack) nv = a;
      end
      m_rv = (nv != m_v);
      if (m_rv) begin m_rs = nv; m_rc = ctx; m_rt = m_ts; end
      if (m_v == 2'b00) begin if (m_pc < 65535) m_pc = m_pc + 1; end
      else m_pc = 0;
      if (lane1 == 2'b11 || lane2 == 2'b11) m_err = 1'b1;
      m_ts = m_ts + 1;
      m_v = nv; m_st = ns;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && cmp_on) begin
      chk("R2 verdict", {30'd0, verdict}, {30'd0, m_v});
      chk("R6 rec_valid", {31'd0, rec_valid}, {31'd0, m_rv});
      chk("R6 rec_state", {30'd0, rec_state}, {30'd0, m_rs});
      chk("R6 rec_ctx", {24'd0, rec_ctx}, {24'd0, m_rc});
      chk("R7 rec_time", rec_time, m_rt);
      chk("R8 escalate", {31'd0, escalate}, {31'd0, (m_v == 2'b00 && m_pc >= LIMIT)});
      chk("R9 lane_err", {31'd0, lane_err}, {31'd0, m_err});
    end
  end

  task automatic step();
    @(negedge clk);
    ctx = ctx + 8'd7;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    lane1 = 2'b00; lane2 = 2'b00; inject = 0; ready = 0; ack = 0; log_ack = 0;
    ctx = 8'h11; limit = LIMIT[LIM_W-1:0];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 verdict", {30'd0, verdict}, 32'd0);
    chk("R1 rec_valid", {31'd0, rec_valid}, 32'd0);
    chk("R1 lane_err", {31'd0, lane_err}, 32'd0);

    // R5: locked gate ignores lanes and an early ack
    lane1 = 2'b01; lane2 = 2'b01; ack = 1; step();
    chk("R5 early ack ignored", {30'd0, verdict}, 32'd0);
    ack = 0; ready = 1; step();
    ready = 0; ack = 1; step();
    chk("R5 no data on unlock edge", {30'd0, verdict}, 32'd0);
    ack = 0; step();
    chk("R2 refuse consensus", {30'd0, verdict}, 32'd1);
    chk("R6 record strobe", {31'd0, rec_valid}, 32'd1);

    lane1 = 2'b10; lane2 = 2'b01; step();
    chk("R2 disagree holds", {30'd0, verdict}, 32'd1);
    lane2 = 2'b10; log_ack = 0; step();
    chk("R3 proceed blocked without log", {30'd0, verdict}, 32'd1);
    log_ack = 1; step();
    chk("R3 proceed with log", {30'd0, verdict}, 32'd2);
    log_ack = 0; lane1 = 2'b00; lane2 = 2'b01; step();
    chk("R2 null lane holds", {30'd0, verdict}, 32'd2);
    lane1 = 2'b11; lane2 = 2'b01; step();
    chk("R9 illegal treated as null", {30'd0, verdict}, 32'd2);
    chk("R9 error flag", {31'd0, lane_err}, 32'd1);

    lane1 = 2'b01; lane2 = 2'b01; inject = 1; ready = 1; ack = 1; step();
    chk("R4 inject forces null", {30'd0, verdict}, 32'd0);
    inject = 0; ready = 0; ack = 0; step();
    chk("R10 stays locked", {30'd0, verdict}, 32'd0);
    repeat (3) step();
    chk("R8 below limit", {31'd0, escalate}, 32'd0);
    step();
    chk("R8 escalate at limit", {31'd0, escalate}, 32'd1);
    ready = 1; step();
    ready = 0; ack = 1; step();
    ack = 0; step();
    chk("R5 released refuse", {30'd0, verdict}, 32'd1);
    chk("R8 escalate cleared", {31'd0, escalate}, 32'd0);
    chk("R9 error sticky", {31'd0, lane_err}, 32'd1);

    for (int i = 0; i < 4000; i++) begin
      lane1   = 2'($urandom_range(0, 3));
      lane2   = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : lane1;
      inject  = ($urandom_range(0, 29) == 0);
      ready   = ($urandom_range(0, 3) == 0);
      ack     = ($urandom_range(0, 3) == 0);
      log_ack = ($urandom_range(0, 1) == 0);
      step();
    end
    finish_run();
  end
endmodule